// File: doc/BRIEF.md
# Character Cell Dot Serializer

This block turns one character-generator word per character cell into a stream of video dots, one dot per dot-clock cycle. Each cell is ten dots wide while the word is eight bits, so a divide-by-ten counter runs beside the shift register. The counter produces the character clock for the rest of the video pipeline and a one-cycle load strobe. On that strobe the shift register takes the next word, so cells follow each other with no gap.

Bit 0 of the word is a graphic-extension flag. When it is set, the two dots that follow the eighth dot repeat the cell's first dot, so a line drawn through a graphic character runs on into its neighbour. When it is clear, those two dots are blank. The word is shifted out most significant bit first, and bit 0 is also the eighth dot. The character generator leaves bit 7 of ordinary characters at zero, which gives them a blank spacing column on the left.

Top module: `dot_serializer`

## Requirements
- R1: The character clock has a period of 10 dot clocks. It is high for the first 5 dot positions of a cell (counter values 0 to 4) and low for the last 5. It is high in the first cycle after reset is released.
- R2: The load strobe is high for exactly one dot clock in every 10. That is the last dot position of a cell (counter value 9), while the character clock is low. After reset is released, the first strobe falls in the 10th dot clock.
- R3: The word on `pattern` is captured at the rising edge on which the load strobe is high. In the 10 cycles after that edge, dots 1 to 8 of the cell are bits 7, 6, 5, 4, 3, 2, 1, 0 of the captured word, in that order.
- R4: When bit 0 of the captured word is 1, dots 9 and 10 of the cell both equal bit 7 of that word.
- R5: When bit 0 of the captured word is 0, dots 9 and 10 of the cell are 0.
- R6: A change on `pattern` at any edge other than a load edge has no effect on the dots of the current cell.
- R7: While reset is asserted, and after its release until the first load edge, `dot` is 0. A word present on `pattern` during that time never shows on `dot`.
- R8: Consecutive cells are contiguous: dot 1 of a cell appears in the cycle right after dot 10 of the previous cell, and the character clock is high in that cycle.
- R9: Reset (active low, asynchronous) asserted in the middle of a cell drives `dot` to 0 and `load` to 0 at once. After release, timing starts again exactly as after power-on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pattern | input | 8 | Character-generator word; bit 0 is the extension flag |
| dot | output | 1 | Serial video dot |
| char_clk | output | 1 | Character clock, dot clock divided by 10 |
| load | output | 1 | Load strobe, high during the last dot of each cell |

## Verification
The load strobe and the character clock come straight from counter state, so they are compared in the same dot cycle as the count they reflect. A word presented while the strobe is high is registered on the next rising edge, and its dot k becomes visible k cycles after that strobe cycle. The bench drives and samples a short time after each falling edge. It presents each word in the strobe cycle and then compares dot k at the k-th sample that follows. The sample on which dot 10 is compared is also the next strobe cycle, so cells chain without resynchronising.

// File: rtl/dotser_pkg.sv
package dotser_pkg;
    // default cell geometry
    localparam int DOTS_PER_CELL = 10;
    localparam int GEN_WORD_W    = 8;
    // position of the graphic-extension flag inside the word
    localparam int EXT_FLAG_BIT  = 0;
endpackage

// File: rtl/dotser_divider.sv
module dotser_divider #(
    parameter int CELL_DOTS = dotser_pkg::DOTS_PER_CELL
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o,
    output logic char_clk_o
);
    localparam int CNT_W = (CELL_DOTS > 1) ? $clog2(CELL_DOTS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CELL_DOTS - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(CELL_DOTS / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             cc;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.cc = (st_d.cnt < HALF);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.cc  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign load_o     = (st_q.cnt == LAST);
    assign char_clk_o = st_q.cc;
endmodule

// File: rtl/dotser_expand.sv
module dotser_expand #(
    parameter int WORD_W    = dotser_pkg::GEN_WORD_W,
    parameter int CELL_DOTS = dotser_pkg::DOTS_PER_CELL,
    parameter int EXT_BIT   = dotser_pkg::EXT_FLAG_BIT
) (
    input  logic [WORD_W-1:0]    word_i,
    output logic [CELL_DOTS-1:0] cell_o
);
    localparam int PAD = CELL_DOTS - WORD_W;

    logic fill_dot;
    assign fill_dot = word_i[EXT_BIT] & word_i[WORD_W-1];

    // the word occupies the leading dot positions, MSB first
    assign cell_o[CELL_DOTS-1 -: WORD_W] = word_i;

    generate
        if (PAD > 0) begin : g_pad
            for (genvar i = 0; i < PAD; i++) begin : g_fill
                assign cell_o[i] = fill_dot;
            end
        end
    endgenerate
endmodule

// File: rtl/dotser_shifter.sv
module dotser_shifter #(
    parameter int CELL_DOTS = dotser_pkg::DOTS_PER_CELL
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [CELL_DOTS-1:0] cell_i,
    output logic                 dot_o
);
    typedef struct packed {
        logic [CELL_DOTS-1:0] sh;
    } shf_state_t;

    shf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.sh = cell_i;
        end else begin
            st_d.sh = {st_q.sh[CELL_DOTS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dot_o = st_q.sh[CELL_DOTS-1];
endmodule

// File: rtl/dot_serializer.sv
module dot_serializer #(
    parameter int CELL_DOTS = dotser_pkg::DOTS_PER_CELL,
    parameter int WORD_W    = dotser_pkg::GEN_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] pattern,
    output logic              dot,
    output logic              char_clk,
    output logic              load
);
    logic [CELL_DOTS-1:0] cell_bits;
    logic                 load_w;

    dotser_divider #(.CELL_DOTS(CELL_DOTS)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_o     (load_w),
        .char_clk_o (char_clk)
    );

    dotser_expand #(
        .WORD_W    (WORD_W),
        .CELL_DOTS (CELL_DOTS),
        .EXT_BIT   (dotser_pkg::EXT_FLAG_BIT)
    ) u_exp (
        .word_i (pattern),
        .cell_o (cell_bits)
    );

    dotser_shifter #(.CELL_DOTS(CELL_DOTS)) u_shf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .cell_i (cell_bits),
        .dot_o  (dot)
    );

    assign load = load_w;
endmodule

// File: rtl/dot_serializer_chk.sv
module dot_serializer_chk #(
    parameter int CELL_DOTS = 10,
    parameter int WORD_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] pattern,
    input logic              dot,
    input logic              char_clk,
    input logic              load
);
    localparam int POS_W = $clog2(CELL_DOTS + 1);

    logic              seen_q;
    logic [WORD_W-1:0] word_q;
    logic [POS_W-1:0]  pos_q;
    logic              exp_dot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            word_q <= '0;
            pos_q  <= '0;
        end else if (load) begin
            seen_q <= 1'b1;
            word_q <= pattern;
            pos_q  <= '0;
        end else if (int'(pos_q) < CELL_DOTS) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    always_comb begin
        exp_dot = 1'b0;
        if (int'(pos_q) < WORD_W) begin
            exp_dot = word_q[WORD_W - 1 - int'(pos_q)];
        end else if (int'(pos_q) < CELL_DOTS) begin
            exp_dot = word_q[0] & word_q[WORD_W-1];
        end
    end

    p_cc_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(char_clk) |-> $past(load));

    p_load_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    p_load_cc_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !char_clk);

    p_dot_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && int'(pos_q) < WORD_W) |-> (dot == exp_dot));

    p_dot_tail_r4_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && int'(pos_q) >= WORD_W && int'(pos_q) < CELL_DOTS) |-> (dot == exp_dot));

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !dot);

    p_gapless_r8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> char_clk);
endmodule

bind dot_serializer dot_serializer_chk #(
    .CELL_DOTS (CELL_DOTS),
    .WORD_W    (WORD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pattern  (pattern),
    .dot      (dot),
    .char_clk (char_clk),
    .load     (load)
);

// File: tb/dot_serializer_test.sv
`timescale 1ns/1ps
module dot_serializer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pattern = 8'hFF;
    logic       dot, char_clk, load;
    int         n_chk = 0;
    int         n_bad = 0;

    always #10 clk = ~clk;

    dot_serializer uut (
        .clk(clk), .rst_n(rst_n), .pattern(pattern),
        .dot(dot), .char_clk(char_clk), .load(load)
    );

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_dot(input logic [7:0] w, input int k);
        if (k <= 8) return w[8-k];
        return w[0] & w[7];
    endfunction

    // releases reset and checks the power-on sequence; ends in a load cycle
    task automatic t_reset_seq(input string tag);
        pattern = 8'hFF;
        rst_n = 1'b0;
        step();
        chk("R7", {tag, " dot in reset"}, dot, 0);
        step();
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (i > 0) step();
            chk("R1", {tag, " char_clk after reset"}, char_clk, (i < 5) ? 1 : 0);
            chk("R2", {tag, " load after reset"}, load, (i == 9) ? 1 : 0);
            chk("R7", {tag, " dot before first load"}, dot, 0);
        end
    endtask

    // presents one word in the current load cycle and checks its 10 dots
    task automatic t_cell(input logic [7:0] w, input bit disturb);
        pattern = w;
        for (int k = 1; k <= 10; k++) begin
            step();
            if (disturb) pattern = ~w ^ 8'(k);
            if (k <= 8)
                chk(disturb ? "R6" : "R3", $sformatf("word %02h dot %0d", w, k), dot, exp_dot(w, k));
            else if (w[0])
                chk(disturb ? "R6" : "R4", $sformatf("word %02h dot %0d", w, k), dot, exp_dot(w, k));
            else
                chk(disturb ? "R6" : "R5", $sformatf("word %02h dot %0d", w, k), dot, exp_dot(w, k));
            chk("R2", $sformatf("load at dot %0d", k), load, (k == 10) ? 1 : 0);
            chk("R1", $sformatf("char_clk at dot %0d", k), char_clk, (k <= 5) ? 1 : 0);
            if (k == 1) chk("R8", "first dot follows previous cell", char_clk, 1);
        end
    endtask

    task automatic t_mid_reset();
        pattern = 8'hFF;
        for (int k = 1; k <= 4; k++) step();
        rst_n = 1'b0;
        #1;
        chk("R9", "dot at async reset", dot, 0);
        chk("R9", "load at async reset", load, 0);
        chk("R9", "char_clk at async reset", char_clk, 1);
        t_reset_seq("R9 restart");
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_seq("R7 power-on");
        t_cell(8'hFF, 1'b0);   // R4 full line, extended
        t_cell(8'hFE, 1'b0);   // R5 normal, trailing blanks
        t_cell(8'hA5, 1'b0);   // R4 extended, first dot 1
        t_cell(8'h25, 1'b0);   // R4 extended, first dot 0
        t_cell(8'h7E, 1'b0);   // R5 ordinary glyph with spacing column
        t_cell(8'h80, 1'b0);   // R5 only first dot
        t_cell(8'h00, 1'b0);   // R5 blank cell
        t_cell(8'h81, 1'b1);   // R6 word changes during the cell
        t_cell(8'h3C, 1'b1);   // R6
        t_mid_reset();
        t_cell(8'hC3, 1'b0);   // R3 after restart
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule